// File: doc/BRIEF.md
# Serial-Fed RAM Initialization Loader

This block fills several on-chip RAM blocks with start-up contents delivered one bit at a time over the user data register of a JTAG test access port. The TAP controller supplies its data-register clock, its capture, shift and update strobes, the serial bit stream and its 8-bit instruction register value. The loader turns that stream into RAM write cycles: a deserializer builds each data word, an update strobe commits it, and a registered write stage presents data, address and one write enable to the RAM blocks. The RAM write clock is the data-register clock itself, so the whole write path lives in one clock domain.

Two instruction codes drive the block. Under the data-load code, shifted bits build a write word. Under the address-load code, shifted bits build a start address, which the update strobe copies into the address counter. Every committed word advances the address counter. When the counter runs past its last address it returns to zero and a one-hot ring of RAM selects moves on to the next RAM block, so one long stream of words can fill every block in turn. Any other instruction code leaves the loader alone. A capture strobe under either loader code clears the matching shift register, so each word or address starts from zero.

Top module: `ldr_jtag_ram_loader`

## Requirements
- R1: A low `rst_n` at a rising `dr_clk` edge resets the block synchronously. While reset is held, `ram_we` is all zero, `ram_wdata` is zero and `ram_waddr` is zero. The first word committed after reset is written to address 0 of RAM 0.
- R2: While `ir_code` equals the data-load code (default 8'h24) and `dr_shift` is high, each rising `dr_clk` edge shifts `ser_in` into bit 0 of the data shift register and moves the older bits up one place. A word therefore arrives most significant bit first.
- R3: A capture strobe under the data-load code clears the data shift register, and so does each commit. Bits shifted before the last capture do not appear in the next word.
- R4: An update strobe under the data-load code commits the word. In the cycle that follows the update edge, `ram_wdata` holds the word, `ram_waddr` holds the current address and exactly one bit of `ram_we` is high. In the cycle after that, `ram_we` is all zero again.
- R5: If fewer than DATA_W bits were shifted since the last clear, the committed word is those bits zero-extended. If more than DATA_W bits were shifted, only the last DATA_W bits remain.
- R6: The address counter increases by one after each committed word.
- R7: Bit i of `ram_we` enables RAM block i. The counter wraps from its all-ones value to zero, and the wrap rotates the selected RAM from block i to block i+1. After the last block the selection returns to block 0.
- R8: Under the address-load code (default 8'h25), shifting fills an ADDR_W-bit address register most significant bit first. An update strobe loads that value into the address counter, and the next committed word is written at that address. The RAM selection does not change.
- R9: Under any other `ir_code`, shift, capture and update strobes leave the data register, the address register and the address counter unchanged, and they produce no write.
- R10: At most one bit of `ram_we` is high at any time. `ram_we` is all zero in every cycle in which `dr_shift` or `dr_capture` is high.
- R11: `ram_wclk` follows `dr_clk`: it is high after each rising edge and low after each falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dr_clk | input | 1 | TAP data-register clock; clocks all loader state |
| rst_n | input | 1 | Synchronous reset, active low |
| dr_capture | input | 1 | TAP capture strobe for the data register |
| dr_shift | input | 1 | TAP shift strobe for the data register |
| dr_update | input | 1 | TAP update strobe for the data register |
| ser_in | input | 1 | Serial data bit from the TAP |
| ir_code | input | 8 | Current instruction register value |
| ram_wdata | output | DATA_W | RAM write data |
| ram_waddr | output | ADDR_W | RAM write address |
| ram_wclk | output | 1 | RAM write clock |
| ram_we | output | NUM_RAMS | One write enable per RAM block |

## Verification
The assertions assume that the input strobes follow the behaviour of a real TAP. Capture, shift and update are never high together. An update lasts exactly one clock cycle. At least one idle cycle separates an update from the next capture or shift, because the TAP always passes through another state between them. The bench drives every strobe through tasks that keep to this ordering: each update task is followed by an idle cycle in which the write is checked. The instruction code changes only at falling edges, so it is stable at every rising edge that uses it.

// File: rtl/ldr_pkg.sv
package ldr_pkg;

    localparam logic [7:0] LDR_OPC_DATA_DEF = 8'h24;
    localparam logic [7:0] LDR_OPC_ADDR_DEF = 8'h25;

    // Decoded per-cycle actions derived from TAP strobes and opcode
    typedef struct packed {
        logic data_shift;
        logic data_clear;
        logic data_commit;
        logic addr_shift;
        logic addr_clear;
        logic addr_load;
    } ldr_ctl_t;

    function automatic ldr_ctl_t ldr_decode(
        input logic [7:0] ir,
        input logic [7:0] opc_data,
        input logic [7:0] opc_addr,
        input logic       cap,
        input logic       sh,
        input logic       upd
    );
        ldr_ctl_t c;
        logic     is_d;
        logic     is_a;
        is_d          = (ir == opc_data);
        is_a          = (ir == opc_addr);
        c.data_shift  = is_d & sh;
        c.data_clear  = is_d & cap;
        c.data_commit = is_d & upd;
        c.addr_shift  = is_a & sh;
        c.addr_clear  = is_a & cap;
        c.addr_load   = is_a & upd;
        return c;
    endfunction

endpackage

// File: rtl/ldr_deser.sv
module ldr_deser #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         clear,
    input  logic         bit_in,
    output logic [W-1:0] word
);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            word <= '0;
        end else if (shift_en) begin
            word <= (word << 1) | W'(bit_in);
        end
    end

endmodule

// File: rtl/ldr_seq.sv
module ldr_seq #(
    parameter int ADDR_W   = 4,
    parameter int NUM_RAMS = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                commit,
    input  logic                load,
    input  logic [ADDR_W-1:0]   load_val,
    output logic [ADDR_W-1:0]   addr,
    output logic [NUM_RAMS-1:0] sel
);

    localparam logic [ADDR_W-1:0]   ADDR_LAST = '1;
    localparam logic [NUM_RAMS-1:0] SEL_FIRST = NUM_RAMS'(1);

    logic [NUM_RAMS-1:0] sel_next;

    generate
        if (NUM_RAMS == 1) begin : g_single
            assign sel_next = sel;
        end else begin : g_ring
            assign sel_next = {sel[NUM_RAMS-2:0], sel[NUM_RAMS-1]};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
            sel  <= SEL_FIRST;
        end else if (commit) begin
            addr <= addr + 1'b1;
            if (addr == ADDR_LAST) begin
                sel <= sel_next;
            end
        end else if (load) begin
            addr <= load_val;
        end
    end

endmodule

// File: rtl/ldr_wr_pipe.sv
module ldr_wr_pipe #(
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 4,
    parameter int NUM_RAMS = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                commit,
    input  logic [DATA_W-1:0]   word_in,
    input  logic [ADDR_W-1:0]   addr_in,
    input  logic [NUM_RAMS-1:0] sel_in,
    output logic [DATA_W-1:0]   wdata,
    output logic [ADDR_W-1:0]   waddr,
    output logic [NUM_RAMS-1:0] we
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdata <= '0;
            waddr <= '0;
            we    <= '0;
        end else begin
            we <= commit ? sel_in : '0;
            if (commit) begin
                wdata <= word_in;
                waddr <= addr_in;
            end
        end
    end

endmodule

// File: rtl/ldr_jtag_ram_loader.sv
module ldr_jtag_ram_loader
    import ldr_pkg::*;
#(
    parameter int         DATA_W   = 8,
    parameter int         ADDR_W   = 4,
    parameter int         NUM_RAMS = 3,
    parameter logic [7:0] OPC_DATA = LDR_OPC_DATA_DEF,
    parameter logic [7:0] OPC_ADDR = LDR_OPC_ADDR_DEF
) (
    input  logic                dr_clk,
    input  logic                rst_n,
    input  logic                dr_capture,
    input  logic                dr_shift,
    input  logic                dr_update,
    input  logic                ser_in,
    input  logic [7:0]          ir_code,
    output logic [DATA_W-1:0]   ram_wdata,
    output logic [ADDR_W-1:0]   ram_waddr,
    output logic                ram_wclk,
    output logic [NUM_RAMS-1:0] ram_we
);

    ldr_ctl_t            ctl;
    logic [DATA_W-1:0]   data_word;
    logic [ADDR_W-1:0]   addr_word;
    logic [ADDR_W-1:0]   addr_cur;
    logic [NUM_RAMS-1:0] sel_cur;

    assign ctl      = ldr_decode(ir_code, OPC_DATA, OPC_ADDR,
                                 dr_capture, dr_shift, dr_update);
    assign ram_wclk = dr_clk;

    ldr_deser #(.W(DATA_W)) data_sr_i (
        .clk      (dr_clk),
        .rst_n    (rst_n),
        .shift_en (ctl.data_shift),
        .clear    (ctl.data_clear | ctl.data_commit),
        .bit_in   (ser_in),
        .word     (data_word)
    );

    ldr_deser #(.W(ADDR_W)) addr_sr_i (
        .clk      (dr_clk),
        .rst_n    (rst_n),
        .shift_en (ctl.addr_shift),
        .clear    (ctl.addr_clear),
        .bit_in   (ser_in),
        .word     (addr_word)
    );

    ldr_seq #(.ADDR_W(ADDR_W), .NUM_RAMS(NUM_RAMS)) seq_i (
        .clk      (dr_clk),
        .rst_n    (rst_n),
        .commit   (ctl.data_commit),
        .load     (ctl.addr_load),
        .load_val (addr_word),
        .addr     (addr_cur),
        .sel      (sel_cur)
    );

    ldr_wr_pipe #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_RAMS(NUM_RAMS)) pipe_i (
        .clk     (dr_clk),
        .rst_n   (rst_n),
        .commit  (ctl.data_commit),
        .word_in (data_word),
        .addr_in (addr_cur),
        .sel_in  (sel_cur),
        .wdata   (ram_wdata),
        .waddr   (ram_waddr),
        .we      (ram_we)
    );

endmodule

// File: rtl/ldr_chk.sv
module ldr_chk #(
    parameter int         ADDR_W   = 4,
    parameter int         NUM_RAMS = 3,
    parameter logic [7:0] OPC_DATA = 8'h24,
    parameter logic [7:0] OPC_ADDR = 8'h25
) (
    input logic                dr_clk,
    input logic                rst_n,
    input logic                dr_capture,
    input logic                dr_shift,
    input logic                dr_update,
    input logic [7:0]          ir_code,
    input logic [ADDR_W-1:0]   ram_waddr,
    input logic [NUM_RAMS-1:0] ram_we
);

    logic                seen;
    logic                loaded;
    logic [ADDR_W-1:0]   last_addr;
    logic [NUM_RAMS-1:0] last_we;
    logic [NUM_RAMS-1:0] last_we_rot;

    generate
        if (NUM_RAMS == 1) begin : g_one
            assign last_we_rot = last_we;
        end else begin : g_rot
            assign last_we_rot = {last_we[NUM_RAMS-2:0], last_we[NUM_RAMS-1]};
        end
    endgenerate

    always_ff @(posedge dr_clk) begin
        if (!rst_n) begin
            seen      <= 1'b0;
            loaded    <= 1'b0;
            last_addr <= '0;
            last_we   <= '0;
        end else if (ram_we != '0) begin
            seen      <= 1'b1;
            loaded    <= 1'b0;
            last_addr <= ram_waddr;
            last_we   <= ram_we;
        end else if (dr_update && ir_code == OPC_ADDR) begin
            loaded <= 1'b1;
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge dr_clk)
        !rst_n |=> (ram_we == '0));

    assert_we_single_cycle_R4: assert property (@(posedge dr_clk) disable iff (!rst_n)
        (ram_we != '0) |=> (ram_we == '0));

    assert_we_needs_update_R4: assert property (@(posedge dr_clk) disable iff (!rst_n)
        (ram_we != '0) |-> $past(dr_update && ir_code == OPC_DATA));

    assert_addr_step_R6: assert property (@(posedge dr_clk) disable iff (!rst_n)
        (ram_we != '0 && seen && !loaded) |-> (ram_waddr == last_addr + 1'b1));

    assert_ring_step_R7: assert property (@(posedge dr_clk) disable iff (!rst_n)
        (ram_we != '0 && seen) |->
            (ram_we == ((last_addr == '1) ? last_we_rot : last_we)));

    assert_we_onehot_R10: assert property (@(posedge dr_clk) disable iff (!rst_n)
        $onehot0(ram_we));

    assert_we_quiet_shift_R10: assert property (@(posedge dr_clk) disable iff (!rst_n)
        (dr_shift || dr_capture) |-> (ram_we == '0));

endmodule

bind ldr_jtag_ram_loader ldr_chk #(
    .ADDR_W   (ADDR_W),
    .NUM_RAMS (NUM_RAMS),
    .OPC_DATA (OPC_DATA),
    .OPC_ADDR (OPC_ADDR)
) chk_i (
    .dr_clk     (dr_clk),
    .rst_n      (rst_n),
    .dr_capture (dr_capture),
    .dr_shift   (dr_shift),
    .dr_update  (dr_update),
    .ir_code    (ir_code),
    .ram_waddr  (ram_waddr),
    .ram_we     (ram_we)
);

// File: tb/ldr_jtag_ram_loader_tb_top.sv
module ldr_jtag_ram_loader_tb_top;

    localparam int         DW  = 8;
    localparam int         AW  = 4;
    localparam int         NR  = 3;
    localparam logic [7:0] OPD = 8'h24;
    localparam logic [7:0] OPA = 8'h25;
    localparam logic [7:0] OPX = 8'h00;

    // {value[7:0], bit count[3:0]}
    localparam logic [11:0] VEC [6] = '{
        {8'hA5, 4'd8}, {8'h3C, 4'd8}, {8'hFF, 4'd8},
        {8'h00, 4'd8}, {8'h81, 4'd8}, {8'h5A, 4'd8}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dr_capture = 1'b0;
    logic          dr_shift = 1'b0;
    logic          dr_update = 1'b0;
    logic          ser_in = 1'b0;
    logic [7:0]    ir_code = 8'h00;
    logic [DW-1:0] ram_wdata;
    logic [AW-1:0] ram_waddr;
    logic          ram_wclk;
    logic [NR-1:0] ram_we;

    int checks = 0;
    int fails  = 0;
    int exp_addr = 0;
    int exp_sel  = 0;

    always #4 clk = ~clk;

    ldr_jtag_ram_loader #(.DATA_W(DW), .ADDR_W(AW), .NUM_RAMS(NR)) dut_i (
        .dr_clk     (clk),
        .rst_n      (rst_n),
        .dr_capture (dr_capture),
        .dr_shift   (dr_shift),
        .dr_update  (dr_update),
        .ser_in     (ser_in),
        .ir_code    (ir_code),
        .ram_wdata  (ram_wdata),
        .ram_waddr  (ram_waddr),
        .ram_wclk   (ram_wclk),
        .ram_we     (ram_we)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic capture(input logic [7:0] ir);
        ir_code = ir;
        dr_capture = 1'b1;
        @(negedge clk);
        dr_capture = 1'b0;
        chk("R10 no write around capture", 32'(ram_we), 0);
    endtask

    task automatic shift_bits(input logic [7:0] ir, input logic [15:0] val, input int n);
        ir_code = ir;
        for (int i = n - 1; i >= 0; i--) begin
            dr_shift = 1'b1;
            ser_in = val[i];
            @(negedge clk);
            if (ram_we !== '0) chk("R10 no write while shifting", 32'(ram_we), 0);
        end
        dr_shift = 1'b0;
    endtask

    task automatic update(input logic [7:0] ir);
        ir_code = ir;
        dr_update = 1'b1;
        @(negedge clk);
        dr_update = 1'b0;
    endtask

    // Called right after a data-load update: checks the write, then the idle cycle
    task automatic commit_check(input string req, input logic [7:0] exp_word);
        chk({req, " wdata"}, 32'(ram_wdata), 32'(exp_word));
        chk("R6 waddr", 32'(ram_waddr), 32'(exp_addr));
        chk("R7 write enable", 32'(ram_we), 32'(1 << exp_sel));
        @(negedge clk);
        chk("R4 enable pulse ends", 32'(ram_we), 0);
        exp_addr = (exp_addr + 1) % (1 << AW);
        if (exp_addr == 0) exp_sel = (exp_sel + 1) % NR;
    endtask

    task automatic write_word(input string req, input logic [15:0] val, input int n);
        logic [7:0] e;
        capture(OPD);
        shift_bits(OPD, val, n);
        update(OPD);
        e = (n >= 8) ? val[7:0] : 8'(val & 16'((1 << n) - 1));
        commit_check(req, e);
    endtask

    task automatic load_addr(input logic [AW-1:0] a);
        capture(OPA);
        shift_bits(OPA, 16'(a), AW);
        update(OPA);
        chk("R8 no write on address load", 32'(ram_we), 0);
        @(negedge clk);
        exp_addr = int'(a);
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset we", 32'(ram_we), 0);
        chk("R1 reset wdata", 32'(ram_wdata), 0);
        chk("R1 reset waddr", 32'(ram_waddr), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: full words, sequential addresses in RAM 0 (R2, R4, R6)
        foreach (VEC[i]) begin
            write_word("R2 table word", {8'h00, VEC[i][11:4]}, int'(VEC[i][3:0]));
        end

        // R5 partial and over-long words
        write_word("R5 partial 3 bits", 16'h000D, 3);
        write_word("R5 overlong 12 bits", 16'h0ABC, 12);

        // R3 a second capture discards earlier bits
        capture(OPD);
        shift_bits(OPD, 16'h0007, 3);
        capture(OPD);
        shift_bits(OPD, 16'h0002, 2);
        update(OPD);
        commit_check("R3 capture clears", 8'h02);

        // R9 foreign opcode: shift, capture and update have no effect
        capture(OPD);
        shift_bits(OPD, 16'h0005, 3);
        capture(OPX);
        shift_bits(OPX, 16'h00FF, 8);
        update(OPX);
        chk("R9 no write on foreign update", 32'(ram_we), 0);
        @(negedge clk);
        shift_bits(8'h11, 16'h000F, 4);
        update(8'h11);
        chk("R9 no write on foreign update 2", 32'(ram_we), 0);
        @(negedge clk);
        update(OPD);
        commit_check("R9 data kept", 8'h05);

        // R8 address load, then R7 wrap and ring rotation
        load_addr(4'hE);
        write_word("R8 at loaded address", 16'h0011, 8);
        write_word("R7 last address", 16'h0022, 8);
        chk("R7 model moved to RAM 1", 32'(exp_sel), 1);
        write_word("R7 after wrap", 16'h0033, 8);
        load_addr(4'hF);
        write_word("R7 RAM 1 last", 16'h0044, 8);
        load_addr(4'hF);
        write_word("R7 RAM 2 last", 16'h0055, 8);
        chk("R7 model back to RAM 0", 32'(exp_sel), 0);
        write_word("R7 RAM 0 again", 16'h0066, 8);

        // R11 write clock follows the data-register clock
        @(posedge clk);
        #1;
        chk("R11 wclk high", 32'(ram_wclk), 1);
        @(negedge clk);
        chk("R11 wclk low", 32'(ram_wclk), 0);

        // R1 reset in mid-operation
        load_addr(4'h7);
        capture(OPD);
        shift_bits(OPD, 16'h0003, 2);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid reset we", 32'(ram_we), 0);
        chk("R1 mid reset waddr", 32'(ram_waddr), 0);
        chk("R1 mid reset wdata", 32'(ram_wdata), 0);
        rst_n = 1'b1;
        exp_addr = 0;
        exp_sel = 0;
        @(negedge clk);
        update(OPD);
        commit_check("R1 cleared word at address 0", 8'h00);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule